// File: doc/BRIEF.md
# Serial Character Transmitter with Buffer-Ready Signalling

This block turns bytes written by a host into asynchronous serial characters on a single output line. Each written byte goes into a sixteen-entry first-in first-out buffer. A serializer takes bytes from the buffer one at a time and sends each as a frame: a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or more high stop bits. A baud enable input sets the timing. It pulses once per oversample tick, and each bit time is sixteen ticks long.

The character format comes from a five-bit line-control input. The serializer reads this input at the moment it takes a byte, so a later change only applies to later characters. An active-low ready output tells a transfer engine when to supply more bytes. In one mode it asks for data only when the buffer is empty. In the other mode it asks for data whenever the buffer has a free entry. An interrupt output signals that the buffer and the serializer have both run dry.

Top module: `uart_tx_dma`

## Requirements
- R1: While `rst_i` is high and after it is released with nothing written, `txd_o` is 1 and `tx_empty_irq_o` is 1. `tx_rdy_n_o` is 0 in buffer-empty mode and also 0 in free-entry mode.
- R2: A frame is a 0 start bit, then the data bits with the least significant bit first, then the parity bit if it is enabled, then stop bits at 1.
- R3: `lcr_i[1:0]` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only the low bits of the byte are sent.
- R4: When `lcr_i[3]` is 1, a parity bit is sent. If `lcr_i[4]` is 1, the parity bit makes the number of ones in data and parity even. If `lcr_i[4]` is 0, it makes that number odd.
- R5: When `lcr_i[2]` is 0, the stop time is 16 ticks. When `lcr_i[2]` is 1, the stop time is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R6: Start, data and parity bits each last 16 baud ticks. While `baud_tick_i` stays low, a frame in progress does not change.
- R7: If the buffer holds another byte when a stop time ends, the next start bit begins in the same cycle, with no idle gap.
- R8: The buffer holds 16 bytes. A write while it is full is dropped, and that byte is never sent.
- R9: When `dma_mode_i` is 0 (buffer-empty mode), `tx_rdy_n_o` is 0 exactly when the buffer holds no byte.
- R10: When `dma_mode_i` is 1 (free-entry mode), `tx_rdy_n_o` goes to 1 in the cycle after the write that fills the sixteenth entry. It returns to 0 as soon as one entry is free.
- R11: `tx_empty_irq_o` is 1 when the buffer is empty and no frame is in progress. An accepted write clears it in the next cycle, and it stays 0 until the last frame's stop time ends.
- R12: The serializer samples `lcr_i` when it takes a byte from the buffer. A change during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| baud_tick_i | input | 1 | Oversample enable, 16 pulses per bit time |
| wr_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | 8 | Byte to queue |
| lcr_i | input | 5 | Line control: [1:0] word length, [2] long stop, [3] parity enable, [4] even parity |
| dma_mode_i | input | 1 | Ready-pin mode: 0 buffer-empty, 1 free-entry |
| txd_o | output | 1 | Serial output line, idles at 1 |
| tx_rdy_n_o | output | 1 | Transfer ready, active low |
| tx_empty_irq_o | output | 1 | Buffer and serializer both empty |

## Verification
Two events can fall in the same cycle. First, a host write can arrive in the cycle where the serializer takes the head byte at the end of a stop time. Second, a write can land on a full buffer in the same cycle as a pop. The bench provokes both by writing one byte per clock while the serializer starts its first frame, and by pushing two bytes more than the buffer holds. It then judges the result in three ways: the sequence of bytes that appears on the line, the exact cycle in which the ready output flips in each mode, and whether the interrupt drops one cycle after an accepted write. Stop time is measured in cycles between back-to-back frames, so any idle gap or a wrong stop length shows up as a count error.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } ser_state_e;

   // lcr field positions
   localparam int LCR_W      = 5;
   localparam int LCR_LONG   = 2;
   localparam int LCR_PEN    = 3;
   localparam int LCR_EVEN   = 4;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic                          wr_i,
   input  logic [WIDTH-1:0]              wr_data_i,
   input  logic                          rd_i,
   output logic [WIDTH-1:0]              rd_data_o,
   output logic [$clog2(DEPTH+1)-1:0]    count_o,
   output logic                          empty_o,
   output logic                          full_o
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_tx_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("uart_tx_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wptr_q, rptr_q;
   logic [CW-1:0]    cnt_q;
   logic             push, pop;
   logic [AW-1:0]    wptr_nx, rptr_nx;

   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == FULL_CNT);
   assign push    = wr_i && !full_o;
   assign pop     = rd_i && !empty_o;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wptr_nx = wptr_q + AW'(1);
         assign rptr_nx = rptr_q + AW'(1);
      end else begin : g_wrap
         assign wptr_nx = (wptr_q == LAST_IDX) ? '0 : wptr_q + AW'(1);
         assign rptr_nx = (rptr_q == LAST_IDX) ? '0 : rptr_q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (push) mem_q[wptr_q] <= wr_data_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wptr_q <= wptr_nx;
         if (pop)  rptr_q <= rptr_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign rd_data_o = mem_q[rptr_q];
   assign count_o   = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (full_o && wr_i && !rd_i) |=> (count_o == FULL_CNT)); // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
      rd_i |-> !empty_o); // R7
endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
   import uart_tx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              tick_i,
   input  logic              avail_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic [LCR_W-1:0]  lcr_i,
   output logic              pop_o,
   output logic              busy_o,
   output logic              txd_o
);
   localparam int TW = $clog2(2 * OVS + 1);
   localparam logic [TW-1:0] T_BIT  = TW'(OVS);
   localparam logic [TW-1:0] T_HALF = TW'(OVS + OVS / 2);
   localparam logic [TW-1:0] T_TWO  = TW'(2 * OVS);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_tx_serializer: OVS must be even and at least 4");
      end
   endgenerate

   ser_state_e        state_q;
   logic [TW-1:0]     tcnt_q, stop_t_q, lim;
   logic [2:0]        bidx_q, last_q;
   logic [BYTE_W-1:0] sh_q;
   logic              pen_q, pval_q, txd_q;
   logic              bit_done, load;

   // character format decoded from the line-control input at load time
   logic [BYTE_W-1:0] mask, masked;
   logic [2:0]        last_nx;
   logic              pval_nx;
   logic [TW-1:0]     stop_nx;

   always_comb begin
      mask    = 8'hFF >> (2'd3 - lcr_i[1:0]);
      masked  = data_i & mask;
      last_nx = 3'd4 + {1'b0, lcr_i[1:0]};
      pval_nx = lcr_i[LCR_EVEN] ? (^masked) : ~(^masked);
      if (!lcr_i[LCR_LONG])         stop_nx = T_BIT;
      else if (lcr_i[1:0] == 2'b00) stop_nx = T_HALF;
      else                          stop_nx = T_TWO;
   end

   assign lim      = (state_q == ST_STOP) ? stop_t_q : T_BIT;
   assign bit_done = tick_i && (tcnt_q == lim - TW'(1));
   assign load     = avail_i &&
                     ((state_q == ST_IDLE) || ((state_q == ST_STOP) && bit_done));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q  <= ST_IDLE;
         txd_q    <= 1'b1;
         tcnt_q   <= '0;
         stop_t_q <= T_BIT;
         bidx_q   <= '0;
         last_q   <= '0;
         sh_q     <= '0;
         pen_q    <= 1'b0;
         pval_q   <= 1'b0;
      end else if (load) begin
         state_q  <= ST_START;
         txd_q    <= 1'b0;
         tcnt_q   <= '0;
         sh_q     <= masked;
         last_q   <= last_nx;
         pen_q    <= lcr_i[LCR_PEN];
         pval_q   <= pval_nx;
         stop_t_q <= stop_nx;
      end else if ((state_q != ST_IDLE) && tick_i) begin
         if (bit_done) begin
            tcnt_q <= '0;
            case (state_q)
               ST_START: begin
                  state_q <= ST_DATA;
                  txd_q   <= sh_q[0];
                  bidx_q  <= '0;
               end
               ST_DATA: begin
                  if (bidx_q == last_q) begin
                     state_q <= pen_q ? ST_PAR : ST_STOP;
                     txd_q   <= pen_q ? pval_q : 1'b1;
                  end else begin
                     bidx_q <= bidx_q + 3'd1;
                     sh_q   <= {1'b0, sh_q[BYTE_W-1:1]};
                     txd_q  <= sh_q[1];
                  end
               end
               ST_PAR: begin
                  state_q <= ST_STOP;
                  txd_q   <= 1'b1;
               end
               default: begin
                  state_q <= ST_IDLE;
                  txd_q   <= 1'b1;
               end
            endcase
         end else begin
            tcnt_q <= tcnt_q + TW'(1);
         end
      end
   end

   assign pop_o  = load;
   assign busy_o = (state_q != ST_IDLE);
   assign txd_o  = txd_q;

   AST_IDLE_MARK: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_IDLE) |-> txd_o); // R1
   AST_START_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_START) |-> !txd_o); // R2
   AST_NO_TICK_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
      (!tick_i && busy_o) |=> ($stable(txd_o) && $stable(state_q))); // R6
   AST_STOP_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_STOP) |-> txd_o); // R5
endmodule

// File: rtl/uart_tx_ready.sv
module uart_tx_ready #(
   parameter int DEPTH = 16
) (
   input  logic                       dma_mode_i,
   input  logic [$clog2(DEPTH+1)-1:0] count_i,
   input  logic                       busy_i,
   output logic                       rdy_n_o,
   output logic                       irq_o
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic is_empty, is_full;
   assign is_empty = (count_i == '0);
   assign is_full  = (count_i == FULL_CNT);

   always_comb begin
      if (dma_mode_i) rdy_n_o = is_full;     // free-entry mode
      else            rdy_n_o = !is_empty;   // buffer-empty mode
   end

   assign irq_o = is_empty && !busy_i;
endmodule

// File: rtl/uart_tx_dma.sv
module uart_tx_dma
   import uart_tx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int OVS   = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              baud_tick_i,
   input  logic              wr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [4:0]        lcr_i,
   input  logic              dma_mode_i,
   output logic              txd_o,
   output logic              tx_rdy_n_o,
   output logic              tx_empty_irq_o
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [BYTE_W-1:0] head;
   logic [CW-1:0]     fcount;
   logic              fempty, ffull, fpop, sbusy;

   uart_tx_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) fifo_i (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .wr_i      (wr_i),
      .wr_data_i (wr_data_i),
      .rd_i      (fpop),
      .rd_data_o (head),
      .count_o   (fcount),
      .empty_o   (fempty),
      .full_o    (ffull)
   );

   uart_tx_serializer #(.OVS(OVS)) ser_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .tick_i  (baud_tick_i),
      .avail_i (!fempty),
      .data_i  (head),
      .lcr_i   (lcr_i),
      .pop_o   (fpop),
      .busy_o  (sbusy),
      .txd_o   (txd_o)
   );

   uart_tx_ready #(.DEPTH(DEPTH)) rdy_i (
      .dma_mode_i (dma_mode_i),
      .count_i    (fcount),
      .busy_i     (sbusy),
      .rdy_n_o    (tx_rdy_n_o),
      .irq_o      (tx_empty_irq_o)
   );

   AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_i && !ffull) |=> !tx_empty_irq_o); // R11
   AST_FULL_HOLDS_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
      (dma_mode_i && ffull && !fpop) |=> (tx_rdy_n_o || !dma_mode_i)); // R10
   AST_EMPTY_MODE0: assert property (@(posedge clk_i) disable iff (rst_i)
      (!dma_mode_i && wr_i && fempty) |=> (tx_rdy_n_o || fpop || !$stable(dma_mode_i))); // R9
   AST_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
      (fpop && sbusy) |=> !txd_o); // R7
endmodule

// File: tb/uart_tx_dma_tb.sv
module uart_tx_dma_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b1;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [4:0] lcr = 5'b00011;
   logic       dma = 1'b0;
   logic       txd, rdy_n, irq;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;  // 200 MHz

   uart_tx_dma dut_i (
      .clk_i (clk), .rst_i (rst), .baud_tick_i (tick), .wr_i (wr),
      .wr_data_i (wdata), .lcr_i (lcr), .dma_mode_i (dma),
      .txd_o (txd), .tx_rdy_n_o (rdy_n), .tx_empty_irq_o (irq)
   );

   // line monitor
   int         mon_cnt = 0;
   logic [7:0] mon_data [64];
   logic       mon_par  [64];
   int         mon_stop [64];
   bit         mon_sok  [64];
   int         mon_bits = 8;
   bit         mon_pen  = 1'b0;
   bit         mon_en   = 1'b1;

   initial begin : line_monitor
      bit pending;
      logic [7:0] d;
      logic p;
      bit sok;
      int sc, nb;
      bit pe;
      pending = 1'b0;
      forever begin
         if (!pending) @(negedge clk);
         if (pending || (mon_en && !rst && txd === 1'b0)) begin
            nb = mon_bits; pe = mon_pen; pending = 1'b0; d = '0; p = 1'b0;
            repeat (8) @(negedge clk);
            sok = (txd == 1'b0);
            for (int i = 0; i < nb; i++) begin
               repeat (16) @(negedge clk);
               d[i] = txd;
            end
            if (pe) begin
               repeat (16) @(negedge clk);
               p = txd;
            end
            repeat (8) @(negedge clk);
            sc = 0;
            while (txd == 1'b1 && sc < 48) begin
               sc++;
               @(negedge clk);
            end
            if (txd == 1'b0) pending = 1'b1;
            mon_data[mon_cnt % 64] = d;
            mon_par[mon_cnt % 64]  = p;
            mon_stop[mon_cnt % 64] = sc;
            mon_sok[mon_cnt % 64]  = sok;
            mon_cnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      wr = 1'b1; wdata = b;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic wait_mon(input int target);
      int n = 0;
      while (mon_cnt < target && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(mon_cnt >= target, "monitor frame count", mon_cnt, target);
   endtask

   function automatic logic [7:0] expect_data(input logic [4:0] l, input logic [7:0] b);
      return b & (8'hFF >> (3 - l[1:0]));
   endfunction

   function automatic logic expect_par(input logic [4:0] l, input logic [7:0] b);
      logic [7:0] m;
      m = expect_data(l, b);
      return l[4] ? (^m) : ~(^m);
   endfunction

   // one frame, line returns idle afterwards
   task automatic t_single(input logic [4:0] l, input logic [7:0] b, input string req);
      int base;
      lcr = l; mon_bits = 5 + int'(l[1:0]); mon_pen = l[3];
      base = mon_cnt;
      put(b);
      wait_mon(base + 1);
      chk(mon_sok[base % 64], {req, " start bit"}, 0, 1);
      chk(mon_data[base % 64] == expect_data(l, b), {req, " data"},
          mon_data[base % 64], expect_data(l, b));
      if (l[3])
         chk(mon_par[base % 64] == expect_par(l, b), {req, " parity"},
             mon_par[base % 64], expect_par(l, b));
      chk(mon_stop[base % 64] == 48, {req, " idle after frame"}, mon_stop[base % 64], 48);
   endtask

   // two queued frames: measures stop time with no idle gap
   task automatic t_stop(input logic [4:0] l, input int exp_stop, input string req);
      int base;
      lcr = l; mon_bits = 5 + int'(l[1:0]); mon_pen = l[3];
      base = mon_cnt;
      put(8'h15);
      put(8'h0A);
      wait_mon(base + 2);
      chk(mon_stop[base % 64] == exp_stop, {req, " stop length"}, mon_stop[base % 64], exp_stop);
      chk(mon_data[(base + 1) % 64] == expect_data(l, 8'h0A), "R7 second frame follows",
          mon_data[(base + 1) % 64], expect_data(l, 8'h0A));
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R1 line high in reset", txd, 1);
      rst = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1, "R1 line idle", txd, 1);
      chk(irq == 1'b1, "R1 irq after reset", irq, 1);
      chk(rdy_n == 1'b0, "R1 ready mode0 after reset", rdy_n, 0);
      dma = 1'b1;
      @(negedge clk);
      chk(rdy_n == 1'b0, "R1 ready mode1 after reset", rdy_n, 0);
      dma = 1'b0;
   endtask

   task automatic t_mode0_irq;
      int n;
      dma = 1'b0; lcr = 5'b00011; mon_bits = 8; mon_pen = 1'b0;
      @(negedge clk);
      wr = 1'b1; wdata = 8'h6E;
      @(negedge clk);
      wr = 1'b0;
      chk(rdy_n == 1'b1, "R9 not ready with byte queued", rdy_n, 1);
      chk(irq == 1'b0, "R11 write clears irq", irq, 0);
      @(negedge clk);
      chk(rdy_n == 1'b0, "R9 ready once buffer drained", rdy_n, 0);
      chk(irq == 1'b0, "R11 irq low while shifting", irq, 0);
      n = 0;
      while (irq == 1'b0 && n < 400) begin @(negedge clk); n++; end
      chk(n >= 150 && n < 170, "R11 irq returns after stop", n, 158);
      repeat (50) @(negedge clk);
   endtask

   task automatic t_stall;
      int n;
      mon_en = 1'b0; tick = 1'b0; lcr = 5'b00011;
      put(8'h3C);
      repeat (40) @(negedge clk);
      chk(txd == 1'b0, "R6 start bit held without tick", txd, 0);
      chk(irq == 1'b0, "R6 frame still pending", irq, 0);
      tick = 1'b1;
      repeat (15) @(negedge clk);
      chk(txd == 1'b0, "R6 start bit lasts 16 ticks", txd, 0);
      @(negedge clk);
      chk(txd == 1'b0, "R6 first data bit (lsb of 3C)", txd, 0);
      repeat (32) @(negedge clk);
      chk(txd == 1'b1, "R6 third data bit", txd, 1);
      n = 0;
      while (irq == 1'b0 && n < 400) begin @(negedge clk); n++; end
      chk(txd == 1'b1, "R6 line idle after stall frame", txd, 1);
      repeat (5) @(negedge clk);
      mon_en = 1'b1;
   endtask

   task automatic t_fill;
      int base, n;
      dma = 1'b1; lcr = 5'b00011; mon_bits = 8; mon_pen = 1'b0;
      base = mon_cnt;
      @(negedge clk);
      for (int i = 0; i < 18; i++) begin
         wr = 1'b1; wdata = 8'h40 + 8'(i);
         @(negedge clk);
         if (i == 15) chk(rdy_n == 1'b0, "R10 ready with a free entry", rdy_n, 0);
      end
      wr = 1'b0;
      chk(rdy_n == 1'b1, "R10 not ready when full", rdy_n, 1);
      repeat (100) @(negedge clk);
      chk(rdy_n == 1'b1, "R10 stays not ready while full", rdy_n, 1);
      n = 0;
      while (rdy_n == 1'b1 && n < 400) begin @(negedge clk); n++; end
      chk(rdy_n == 1'b0, "R10 ready again after a pop", rdy_n, 0);
      wait_mon(base + 17);
      for (int i = 0; i < 17; i++)
         chk(mon_data[(base + i) % 64] == 8'h40 + 8'(i), "R8 buffered order",
             mon_data[(base + i) % 64], 8'h40 + i);
      chk(mon_stop[(base + 16) % 64] == 48, "R8 write to full buffer dropped",
          mon_stop[(base + 16) % 64], 48);
      chk(mon_cnt == base + 17, "R8 only 17 frames", mon_cnt, base + 17);
      dma = 1'b0;
   endtask

   task automatic t_lcr_latch;
      int base;
      lcr = 5'b00011; mon_bits = 8; mon_pen = 1'b0;
      base = mon_cnt;
      put(8'hB7);
      repeat (20) @(negedge clk);
      lcr = 5'b11100;
      wait_mon(base + 1);
      chk(mon_data[base % 64] == 8'hB7, "R12 format held for frame", mon_data[base % 64], 8'hB7);
      chk(mon_stop[base % 64] == 48, "R12 no parity inserted", mon_stop[base % 64], 48);
      lcr = 5'b00011;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_single(5'b00011, 8'hA5, "R2 8-bit frame");
      t_single(5'b00000, 8'hFB, "R3 5-bit");
      t_single(5'b00001, 8'hEA, "R3 6-bit");
      t_single(5'b00010, 8'hD3, "R3 7-bit");
      t_single(5'b11010, 8'h35, "R4 even parity");
      t_single(5'b01010, 8'h35, "R4 odd parity");
      t_single(5'b11011, 8'h80, "R4 even parity 8-bit");
      t_stop(5'b00011, 16, "R5 one stop");
      t_stop(5'b00111, 32, "R5 two stops");
      t_stop(5'b00100, 24, "R5 one and a half stops");
      t_stop(5'b00101, 32, "R5 6-bit long stop");
      t_stop(5'b00000, 16, "R5 5-bit short stop");
      t_stop(5'b11110, 32, "R5 parity then two stops");
      t_mode0_irq();
      t_stall();
      t_fill();
      t_lcr_latch();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule